// File: doc/BRIEF.md
# Three-Wire Serial Timekeeper Bus Master

This block is the bit-level engine for a three-wire serial bus of the kind used by small real-time clock chips. The bus has a serial clock output, one bidirectional data line and an active-high enable line that frames each transaction. A higher-level sequencer issues one command at a time: open a transaction, shift a byte out, shift a byte in, or close the transaction. It then waits for the one-cycle done pulse, and after a read it takes the received byte.

Bits travel least significant bit first in both directions. On a write the clock is pulled low, the bit is placed on the data line, and the clock rises one time unit later so that the slave latches the bit. On a read the clock is pulled low, and at the end of that low unit the data line is sampled into the top of a right-shifting register before the clock rises. A time unit is `DIV` cycles of the system clock. The data driver enable is a separate output, so the tri-state buffer can sit in the pad ring. Register addressing and write-protect policy belong to the sequencer and are not part of this block.

Top module: `rtc3w_master`

## Requirements
- R1: A write command (cmd = 4'b0010) shifts `wrData` out LSB first over 8 bits. Each bit takes two time units: `busClk` is low for one unit with the bit already on `busDataOut`, then high for one unit. The clock falls in the cycle after the command is accepted.
- R2: A read command (cmd = 4'b0100) runs the same clock pattern with the driver released. At the last cycle of each low unit, `busDataIn` is sampled into the MSB of a right-shifting register. When done pulses, `rdData` holds the byte, with the first bit sampled in bit 0. Other commands leave `rdData` unchanged.
- R3: `busDataOe` is high only from the acceptance of a write until its eighth bit ends. It falls in the same cycle that done rises, and it stays low during reads, starts and stops.
- R4: A start command (cmd = 4'b0001) drives `busClk` low. It leaves `busEn` unchanged for SETUP_UNITS, holds `busEn` low for HOLD_UNITS, and then raises `busEn`.
- R5: A stop command (cmd = 4'b1000) waits END_UNITS with the bus unchanged and then drops `busEn`. It does not move `busClk`.
- R6: A command is accepted only when `busy` is low and exactly one bit of `cmd` is set. Any other pattern, or any command issued while busy, has no effect on the bus, on `busy` or on `done`.
- R7: `busy` is high from the cycle after acceptance until the final edge of the command. In that cycle `done` is high for exactly one cycle and `busy` is already low.
- R8: After reset, `busClk`, `busEn`, `busDataOe`, `busy`, `done` and `rdData` are all zero.
- R9: One time unit is exactly `DIV` system clock cycles. A byte takes 16·DIV cycles, a start takes (SETUP_UNITS+HOLD_UNITS)·DIV cycles and a stop takes END_UNITS·DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmd | input | 4 | One-hot command: bit0 start, bit1 write, bit2 read, bit3 stop |
| wrData | input | 8 | Byte to shift out, sampled when a write is accepted |
| rdData | output | 8 | Last byte received |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| busClk | output | 1 | Serial bus clock |
| busEn | output | 1 | Active-high transaction enable |
| busDataOut | output | 1 | Data line output value |
| busDataOe | output | 1 | Data line driver enable |
| busDataIn | input | 1 | Data line input value |

## Verification
The assertions assume that the bus lines move only as a result of an accepted command. They also assume that a write is the only command that turns the driver on, so the checker relates changes of these lines to `busy` and to the command seen at the edge of acceptance. The bench holds `busDataIn` steady for each whole bit period, as a slave would, and changes its inputs only at falling clock edges. It sends commands while busy and command patterns with several bits set, so the ignore rule is exercised, and it never needs a clean command to be held for more than one cycle.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;
  localparam int CMD_W = 4;
  localparam int CMD_START = 0;
  localparam int CMD_WRITE = 1;
  localparam int CMD_READ  = 2;
  localparam int CMD_STOP  = 3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_HOLD, PH_LOW, PH_HIGH, PH_END
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shiftOut;
    logic sampleIn;
    logic publish;
  } dpStrobe_t;
endpackage

// File: rtl/rtc3w_dp.sv
module rtc3w_dp
  import rtc3w_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dataIn,
  output logic              dataOut,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      rdData <= '0;
    end else begin
      if (stb.load)          shReg <= wrData;
      else if (stb.shiftOut) shReg <= {1'b0, shReg[DATA_W-1:1]};
      else if (stb.sampleIn) shReg <= {dataIn, shReg[DATA_W-1:1]};
      if (stb.publish)       rdData <= shReg;
    end
  end

  assign dataOut = shReg[0];
endmodule

// File: rtl/rtc3w_ctrl.sv
module rtc3w_ctrl
  import rtc3w_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV         = 200,
  parameter int SETUP_UNITS = 1,
  parameter int HOLD_UNITS  = 5,
  parameter int END_UNITS   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CMD_W-1:0] cmd,
  output dpStrobe_t        stb,
  output logic             busy,
  output logic             done,
  output logic             busClk,
  output logic             busEn,
  output logic             busDataOe
);
  localparam int MAXU = (HOLD_UNITS > SETUP_UNITS)
                        ? ((HOLD_UNITS > END_UNITS) ? HOLD_UNITS : END_UNITS)
                        : ((SETUP_UNITS > END_UNITS) ? SETUP_UNITS : END_UNITS);
  localparam int TW = $clog2(MAXU * DIV) + 1;
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [TW-1:0] T_BIT   = TW'(DIV - 1);
  localparam logic [TW-1:0] T_SETUP = TW'(SETUP_UNITS * DIV - 1);
  localparam logic [TW-1:0] T_HOLD  = TW'(HOLD_UNITS * DIV - 1);
  localparam logic [TW-1:0] T_END   = TW'(END_UNITS * DIV - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  phase_t        phase;
  logic [TW-1:0] timer;
  logic [BW-1:0] bitCnt;
  logic          isWrite;
  logic          cmdOk;
  logic          expired;
  logic          lastBit;

  assign cmdOk   = (phase == PH_IDLE) && $onehot(cmd);
  assign expired = (timer == '0);
  assign lastBit = (bitCnt == LAST_BIT);

  always_comb begin
    stb.load     = cmdOk && cmd[CMD_WRITE];
    stb.sampleIn = (phase == PH_LOW) && expired && !isWrite;
    stb.shiftOut = (phase == PH_HIGH) && expired && isWrite && !lastBit;
    stb.publish  = (phase == PH_HIGH) && expired && !isWrite && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      timer     <= '0;
      bitCnt    <= '0;
      isWrite   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      busClk    <= 1'b0;
      busEn     <= 1'b0;
      busDataOe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase != PH_IDLE && !expired) timer <= timer - 1'b1;
      unique case (phase)
        PH_IDLE: if (cmdOk) begin
          busy <= 1'b1;
          if (cmd[CMD_START]) begin
            busClk <= 1'b0;
            timer  <= T_SETUP;
            phase  <= PH_SETUP;
          end else if (cmd[CMD_STOP]) begin
            timer <= T_END;
            phase <= PH_END;
          end else begin
            busClk    <= 1'b0;
            isWrite   <= cmd[CMD_WRITE];
            busDataOe <= cmd[CMD_WRITE];
            bitCnt    <= '0;
            timer     <= T_BIT;
            phase     <= PH_LOW;
          end
        end
        PH_SETUP: if (expired) begin
          busEn <= 1'b0;
          timer <= T_HOLD;
          phase <= PH_HOLD;
        end
        PH_HOLD: if (expired) begin
          busEn <= 1'b1;
          busy  <= 1'b0;
          done  <= 1'b1;
          phase <= PH_IDLE;
        end
        PH_LOW: if (expired) begin
          busClk <= 1'b1;
          timer  <= T_BIT;
          phase  <= PH_HIGH;
        end
        PH_HIGH: if (expired) begin
          if (lastBit) begin
            busDataOe <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b1;
            phase     <= PH_IDLE;
          end else begin
            busClk <= 1'b0;
            bitCnt <= bitCnt + 1'b1;
            timer  <= T_BIT;
            phase  <= PH_LOW;
          end
        end
        PH_END: if (expired) begin
          busEn <= 1'b0;
          busy  <= 1'b0;
          done  <= 1'b1;
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master
  import rtc3w_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV         = 200,
  parameter int SETUP_UNITS = 1,
  parameter int HOLD_UNITS  = 5,
  parameter int END_UNITS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              busClk,
  output logic              busEn,
  output logic              busDataOut,
  output logic              busDataOe,
  input  logic              busDataIn
);
  dpStrobe_t stb;

  rtc3w_ctrl #(
    .DATA_W(DATA_W), .DIV(DIV), .SETUP_UNITS(SETUP_UNITS),
    .HOLD_UNITS(HOLD_UNITS), .END_UNITS(END_UNITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stb(stb), .busy(busy), .done(done),
    .busClk(busClk), .busEn(busEn), .busDataOe(busDataOe)
  );

  rtc3w_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .dataIn(busDataIn),
    .dataOut(busDataOut), .rdData(rdData)
  );
endmodule

// File: rtl/rtc3w_chk.sv
module rtc3w_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] cmd,
  input logic       busy,
  input logic       done,
  input logic       busClk,
  input logic       busEn,
  input logic       busDataOe
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R3
  oe_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> busy);
  // R3
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDataOe) |-> ($past(cmd) == 4'b0010) && $past(!busy));
  // R6
  ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $countones(cmd) != 1) |=> ($stable(busClk) && $stable(busEn) && !busy && !done));
  // R4
  en_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busEn) |-> $past(busy));
  // R4
  en_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busEn) |-> done && !busClk);
endmodule

bind rtc3w_master rtc3w_chk u_chk (.*);

// File: tb/sim_rtc3w_master.sv
`timescale 1ns/1ps
module sim_rtc3w_master;
  localparam int DIV = 4;
  localparam int SU = 1, HU = 5, EU = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] cmd = '0;
  logic [7:0] wrData = '0, rdData;
  logic busy, done, busClk, busEn, busDataOut, busDataOe;
  logic busDataIn = 1'b0;
  int checks = 0, errors = 0;
  logic mClk = 1'b0, mEn = 1'b0;
  logic [7:0] mRd = '0;

  always #2.5 clk = ~clk;

  rtc3w_master #(.DATA_W(8), .DIV(DIV), .SETUP_UNITS(SU), .HOLD_UNITS(HU),
                 .END_UNITS(EU)) u0 (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmpCycle(string req, logic eClk, logic eEn, logic eOe, logic eBusy,
                          logic eDone, logic chkOut, logic eOut);
    chk(req, "busClk", busClk, eClk);
    chk(req, "busEn", busEn, eEn);
    chk("R3", "busDataOe", busDataOe, eOe);
    chk("R7", "busy", busy, eBusy);
    chk("R7", "done", done, eDone);
    if (chkOut) chk("R1", "busDataOut", busDataOut, eOut);
  endtask

  // idle cycles: nothing may change (R6)
  task automatic idleFor(int n, logic [3:0] junk);
    for (int i = 0; i < n; i++) begin
      cmd = (i == 0) ? junk : 4'b0000;
      @(negedge clk);
      cmpCycle("R6", mClk, mEn, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R6", "rdData", rdData, mRd);
    end
    cmd = '0;
  endtask

  // issue a command and compare every cycle with the model (R9 timing)
  task automatic runCmd(int kind, logic [7:0] wd, logic [7:0] rb, int injAt, logic [3:0] inj);
    int n;
    string rq;
    wrData = wd;
    cmd = 4'b0001 << kind;
    @(negedge clk);
    cmd = '0;
    wrData = ~wd;
    case (kind)
      0: begin n = (SU + HU) * DIV; rq = "R4"; end
      3: begin n = EU * DIV; rq = "R5"; end
      default: begin n = 16 * DIV; rq = (kind == 1) ? "R1" : "R2"; end
    endcase
    for (int k = 0; k <= n; k++) begin
      logic eClk, eEn, eOe;
      if (kind == 2 && k < n) busDataIn = rb[k / (2 * DIV)];
      cmd = (k == injAt) ? inj : 4'b0000;
      eEn = mEn; eClk = mClk; eOe = 1'b0;
      case (kind)
        0: begin
          eClk = 1'b0;
          if (k >= SU * DIV) eEn = (k >= n);
        end
        3: if (k >= n) eEn = 1'b0;
        default: begin
          eClk = (k >= n) ? 1'b1 : 1'((k / DIV) % 2);
          eOe  = (kind == 1) && (k < n);
        end
      endcase
      cmpCycle(rq, eClk, eEn, eOe, k < n, k == n, eOe, wd[(k / (2 * DIV)) % 8]);
      if (k == n) begin
        mClk = eClk; mEn = eEn;
        if (kind == 2) mRd = rb;
        chk("R2", "rdData", rdData, mRd);
      end else @(negedge clk);
    end
    cmd = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8", "busClk", busClk, 0);
    chk("R8", "busEn", busEn, 0);
    chk("R8", "busDataOe", busDataOe, 0);
    chk("R8", "busy", busy, 0);
    chk("R8", "done", done, 0);
    chk("R8", "rdData", rdData, 0);
    runCmd(0, 8'h00, 8'h00, -1, 4'b0);
    idleFor(2, 4'b0);
    runCmd(1, 8'hA5, 8'h00, -1, 4'b0);
    runCmd(2, 8'h00, 8'h3C, -1, 4'b0);
    idleFor(3, 4'b0110);               // R6 multi-hot ignored
    runCmd(1, 8'h01, 8'h00, 5, 4'b0100); // R6 read while busy ignored
    runCmd(2, 8'h00, 8'h80, 9, 4'b0001); // R6 start while busy ignored
    runCmd(3, 8'h00, 8'h00, 3, 4'b0010);
    idleFor(2 * DIV, 4'b0011);
    runCmd(0, 8'h00, 8'h00, -1, 4'b0);
    runCmd(1, 8'hFF, 8'h00, -1, 4'b0);
    runCmd(0, 8'h00, 8'h00, -1, 4'b0);  // restart with enable high (R4)
    runCmd(2, 8'h00, 8'h5A, -1, 4'b0);
    runCmd(2, 8'h00, 8'hFE, -1, 4'b0);
    runCmd(1, 8'h6E, 8'h00, -1, 4'b0);  // R2 rdData kept after write
    runCmd(3, 8'h00, 8'h00, -1, 4'b0);
    idleFor(4, 4'b1111);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule